// File: doc/BRIEF.md
# Reloadable Timer Prescaler Stage

This block divides the timer source clock before it reaches a 32-bit down-counter. A 16-bit prescale count runs down on each enabled source cycle. When it sits at zero, the next source edge refills it from a software-set divide value and drives a one-cycle decrement tick into the main counter. A divide value of N therefore yields one tick every N+1 enabled cycles. A divide value of zero yields a tick on every enabled cycle.

Software sets the divide value one byte at a time through a small register port. It can read the live prescale count but cannot write it. The only ways to change the count are a natural refill and a software reload pulse, which copies the divide value into the count at once. The main counter is included so that the division is visible. It wraps through zero and flags each wrap.

Top module: `tmr_prescale_top`

## Requirements
- R1: After reset the prescale count, the divide value and the main counter are all zero, and `wrap_o` and `tick_o` are low while `en_i` is low.
- R2: Register address 0 reads `{count[7:0], divide[7:0]}` and address 1 reads `{count[15:8], divide[15:8]}`, with the count byte in bits 15:8 and the divide byte in bits 7:0. A write with `we_i` high stores `wdata_i` into the divide byte selected by `addr_i`.
- R3: A register write never changes the prescale count.
- R4: On an enabled cycle with no reload, a nonzero count decrements by one.
- R5: On an enabled cycle with no reload and a count of zero, `tick_o` is high in that cycle. At the following edge the count loads the divide value and the main counter decrements by one. The main counter holds in every other cycle.
- R6: With divide value N and the count starting at N, exactly floor(C/(N+1)) ticks occur in C enabled cycles. N = 0 ticks on every enabled cycle.
- R7: A high `reload_i` loads the count from the divide value at the next edge, whether or not `en_i` is high.
- R8: If `reload_i` is high in a cycle where the count is zero and `en_i` is high, a single load takes place, `tick_o` stays low and the main counter does not change.
- R9: While `en_i` is low and `reload_i` is low, the count holds its value and `tick_o` stays low.
- R10: A tick while the main counter is zero wraps it to all ones. `wrap_o` is high for exactly the one cycle that follows that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Timer source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| en_i | input | 1 | Timer run enable |
| reload_i | input | 1 | Software reload pulse |
| we_i | input | 1 | Divide byte write enable |
| addr_i | input | 1 | Register select (0 low byte, 1 high byte) |
| wdata_i | input | 8 | Divide byte write data |
| rdata_o | output | 16 | Selected register: count byte in 15:8, divide byte in 7:0 |
| tick_o | output | 1 | Decrement tick to the main counter |
| cnt_o | output | 32 | Main down-counter value |
| wrap_o | output | 1 | One-cycle pulse after the main counter passes through zero |

## Verification
The hardest case to reach is a reload pulse that lands in the exact cycle where the count is already zero. The bench sets a small divide value, reloads, and steps the enable one cycle at a time while it reads the count back through both register addresses. It raises the reload only in the cycle where that readback shows zero. It then confirms that no tick appears, that the count holds the divide value and that the main counter has not moved. The wrap flag is reached directly after reset: the main counter starts at zero, so a single tick with divide value 0 drives it through zero.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam int unsigned BYTE_W = 8;

  function automatic int unsigned addr_bits(input int unsigned lanes);
    return (lanes > 1) ? $clog2(lanes) : 1;
  endfunction
endpackage

// File: rtl/psc_div_regs.sv
module psc_div_regs #(
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned BYTE_W = 8,
  parameter int unsigned LANES  = PSC_W / BYTE_W,
  parameter int unsigned AW     = 1
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  input  logic [PSC_W-1:0]    psc_i,
  output logic [PSC_W-1:0]    div_o,
  output logic [2*BYTE_W-1:0] rdata_o
);
  logic [LANES-1:0][BYTE_W-1:0] div_q;
  logic [LANES-1:0][BYTE_W-1:0] psc_b;

  assign psc_b = psc_i;
  assign div_o = div_q;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        div_q[g] <= '0;
      end else if (we_i && (int'(addr_i) == g)) begin
        div_q[g] <= wdata_i;
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    if (int'(addr_i) < LANES) begin
      rdata_o = {psc_b[addr_i], div_q[addr_i]};
    end
  end
endmodule

// File: rtl/psc_core.sv
module psc_core #(
  parameter int unsigned PSC_W = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             reload_i,
  input  logic [PSC_W-1:0] div_i,
  output logic [PSC_W-1:0] psc_o,
  output logic             tick_o
);
  logic [PSC_W-1:0] psc_q;
  logic             at_zero;

  assign at_zero = (psc_q == '0);
  // software reload wins and suppresses the tick
  assign tick_o  = en_i && !reload_i && at_zero;
  assign psc_o   = psc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      psc_q <= '0;
    end else if (reload_i) begin
      psc_q <= div_i;
    end else if (en_i) begin
      psc_q <= at_zero ? div_i : psc_q - 1'b1;
    end
  end
endmodule

// File: rtl/main_dn_cnt.sv
module main_dn_cnt #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             tick_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic             wrap_o
);
  logic [CNT_W-1:0] cnt_q;
  logic             wrap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q  <= '0;
      wrap_q <= 1'b0;
    end else begin
      wrap_q <= tick_i && (cnt_q == '0);
      if (tick_i) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign cnt_o  = cnt_q;
  assign wrap_o = wrap_q;
endmodule

// File: rtl/tmr_prescale_top.sv
module tmr_prescale_top #(
  parameter int unsigned PSC_W  = 16,
  parameter int unsigned CNT_W  = 32,
  parameter int unsigned BYTE_W = tmr_pkg::BYTE_W,
  localparam int unsigned LANES = PSC_W / BYTE_W,
  localparam int unsigned AW    = tmr_pkg::addr_bits(LANES)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                en_i,
  input  logic                reload_i,
  input  logic                we_i,
  input  logic [AW-1:0]       addr_i,
  input  logic [BYTE_W-1:0]   wdata_i,
  output logic [2*BYTE_W-1:0] rdata_o,
  output logic                tick_o,
  output logic [CNT_W-1:0]    cnt_o,
  output logic                wrap_o
);
  logic [PSC_W-1:0] psc_q;
  logic [PSC_W-1:0] div_q;
  logic             tick;

  psc_div_regs #(
    .PSC_W (PSC_W),
    .BYTE_W(BYTE_W),
    .LANES (LANES),
    .AW    (AW)
  ) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (we_i),
    .addr_i (addr_i),
    .wdata_i(wdata_i),
    .psc_i  (psc_q),
    .div_o  (div_q),
    .rdata_o(rdata_o)
  );

  psc_core #(.PSC_W(PSC_W)) u_core (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .en_i    (en_i),
    .reload_i(reload_i),
    .div_i   (div_q),
    .psc_o   (psc_q),
    .tick_o  (tick)
  );

  main_dn_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .tick_i(tick),
    .cnt_o (cnt_o),
    .wrap_o(wrap_o)
  );

  assign tick_o = tick;
endmodule

// File: rtl/tmr_prescale_chk.sv
module tmr_prescale_chk #(
  parameter int unsigned PSC_W = 16,
  parameter int unsigned CNT_W = 32
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             en_i,
  input logic             reload_i,
  input logic             tick_o,
  input logic [CNT_W-1:0] cnt_o,
  input logic             wrap_o,
  input logic [PSC_W-1:0] psc_i,
  input logic [PSC_W-1:0] div_i
);
  assert_count_down_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_i && !reload_i && psc_i != '0) |=> (psc_i == $past(psc_i) - 1'b1));

  assert_tick_refill_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_o |=> (psc_i == $past(div_i) && cnt_o == $past(cnt_o) - 1'b1));

  assert_cnt_hold_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tick_o |=> $stable(cnt_o));

  assert_reload_load_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |=> (psc_i == $past(div_i)));

  assert_no_tick_on_reload_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reload_i |-> !tick_o);

  assert_idle_hold_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_i && !reload_i) |=> $stable(psc_i));

  assert_idle_no_tick_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |-> !tick_o);

  assert_wrap_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tick_o && cnt_o == '0) |=> (wrap_o && cnt_o == '1));

  assert_wrap_single_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wrap_o |=> !wrap_o);
endmodule

bind tmr_prescale_top tmr_prescale_chk #(.PSC_W(PSC_W), .CNT_W(CNT_W)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .en_i    (en_i),
  .reload_i(reload_i),
  .tick_o  (tick_o),
  .cnt_o   (cnt_o),
  .wrap_o  (wrap_o),
  .psc_i   (psc_q),
  .div_i   (div_q)
);

// File: tb/tmr_prescale_top_test.sv
module tmr_prescale_top_test;
  localparam int CLK_P = 10;

  typedef struct packed {
    logic [15:0] div;
    logic [15:0] cycles;
    logic [15:0] ticks;
  } vec_t;

  localparam int NVEC = 5;
  localparam vec_t VECS [NVEC] = '{
    '{div: 16'd0,   cycles: 16'd10,  ticks: 16'd10},
    '{div: 16'd3,   cycles: 16'd12,  ticks: 16'd3},
    '{div: 16'd4,   cycles: 16'd14,  ticks: 16'd2},
    '{div: 16'd258, cycles: 16'd600, ticks: 16'd2},
    '{div: 16'd1,   cycles: 16'd7,   ticks: 16'd3}
  };

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        en_i = 1'b0;
  logic        reload_i = 1'b0;
  logic        we_i = 1'b0;
  logic [0:0]  addr_i = '0;
  logic [7:0]  wdata_i = '0;
  logic [15:0] rdata_o;
  logic        tick_o;
  logic [31:0] cnt_o;
  logic        wrap_o;

  int checks = 0;
  int errors = 0;
  logic [31:0] cnt_exp = '0;

  tmr_prescale_top uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .en_i(en_i), .reload_i(reload_i),
    .we_i(we_i), .addr_i(addr_i), .wdata_i(wdata_i), .rdata_o(rdata_o),
    .tick_o(tick_o), .cnt_o(cnt_o), .wrap_o(wrap_o)
  );

  always #(CLK_P/2) clk_i = ~clk_i;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [7:0] d);
    @(negedge clk_i);
    we_i = 1'b1; addr_i = a; wdata_i = d;
    @(negedge clk_i);
    we_i = 1'b0;
  endtask

  task automatic pulse_reload();
    @(negedge clk_i);
    reload_i = 1'b1;
    @(negedge clk_i);
    reload_i = 1'b0;
  endtask

  // called in the low phase after a negedge
  task automatic rd_psc(output logic [15:0] v);
    addr_i = 1'b0; #1; v[7:0]  = rdata_o[15:8];
    addr_i = 1'b1; #1; v[15:8] = rdata_o[15:8];
  endtask

  task automatic set_div(input logic [15:0] d);
    wr(1'b0, d[7:0]);
    wr(1'b1, d[15:8]);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++; errors++;
    $display("FAIL watchdog actual=timeout expected=done");
    finish_run();
  end

  initial begin
    logic [15:0] p;
    logic [15:0] p2;
    int nt;

    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);

    // R1 reset state
    addr_i = 1'b0; #1; chk("R1 reg0", {16'h0, rdata_o}, 32'h0);
    addr_i = 1'b1; #1; chk("R1 reg1", {16'h0, rdata_o}, 32'h0);
    chk("R1 cnt", cnt_o, 32'h0);
    chk("R1 wrap", {31'h0, wrap_o}, 32'h0);
    chk("R1 tick", {31'h0, tick_o}, 32'h0);

    // R2 divide bytes land in their own register, bits 7:0
    set_div(16'h3CA5);
    @(negedge clk_i);
    addr_i = 1'b0; #1; chk("R2 low reg", {16'h0, rdata_o}, 32'h00A5);
    addr_i = 1'b1; #1; chk("R2 high reg", {16'h0, rdata_o}, 32'h003C);

    // R10 wrap: counter is zero, divide 0 gives one tick
    set_div(16'h0000);
    @(negedge clk_i);
    en_i = 1'b1; #1;
    chk("R5 tick at zero count", {31'h0, tick_o}, 32'h1);
    @(negedge clk_i);
    en_i = 1'b0; #1;
    chk("R10 wrap value", cnt_o, 32'hFFFF_FFFF);
    chk("R10 wrap flag", {31'h0, wrap_o}, 32'h1);
    @(negedge clk_i); #1;
    chk("R10 wrap flag single cycle", {31'h0, wrap_o}, 32'h0);
    cnt_exp = 32'hFFFF_FFFF;

    // R7 reload while disabled
    set_div(16'h0105);
    pulse_reload();
    rd_psc(p);
    chk("R7 reload with enable low", {16'h0, p}, 32'h0105);

    // R3 write does not touch the count
    wr(1'b0, 8'h77);
    @(negedge clk_i);
    rd_psc(p);
    chk("R3 count unchanged by write", {16'h0, p}, 32'h0105);

    // R4 two enabled cycles
    @(negedge clk_i); en_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); en_i = 1'b0;
    rd_psc(p);
    chk("R4 count decrement", {16'h0, p}, 32'h0103);

    // R9 hold while disabled
    nt = 0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk_i); #1;
      if (tick_o) nt++;
    end
    rd_psc(p2);
    chk("R9 count held", {16'h0, p2}, {16'h0, p});
    chk("R9 no tick", nt, 0);
    chk("R5 cnt held without tick", cnt_o, cnt_exp);

    // R8 reload coincident with zero count
    set_div(16'h0002);
    pulse_reload();
    @(negedge clk_i); en_i = 1'b1;
    @(negedge clk_i);
    @(negedge clk_i); en_i = 1'b0;
    rd_psc(p);
    chk("R8 count reached zero", {16'h0, p}, 32'h0);
    @(negedge clk_i);
    en_i = 1'b1; reload_i = 1'b1; #1;
    chk("R8 no tick on coincident reload", {31'h0, tick_o}, 32'h0);
    @(negedge clk_i);
    en_i = 1'b0; reload_i = 1'b0;
    rd_psc(p);
    chk("R8 single load", {16'h0, p}, 32'h0002);
    chk("R8 cnt unchanged", cnt_o, cnt_exp);

    // R6 vector table
    for (int v = 0; v < NVEC; v++) begin
      set_div(VECS[v].div);
      pulse_reload();
      rd_psc(p);
      chk("R7 reload loads divide", {16'h0, p}, {16'h0, VECS[v].div});
      nt = 0;
      for (int c = 0; c < int'(VECS[v].cycles); c++) begin
        @(negedge clk_i);
        en_i = 1'b1; #1;
        if (tick_o) nt++;
      end
      @(negedge clk_i);
      en_i = 1'b0; #1;
      cnt_exp = cnt_exp - 32'(VECS[v].ticks);
      chk("R6 tick count", nt, {16'h0, VECS[v].ticks});
      chk("R5 main counter", cnt_o, cnt_exp);
    end

    finish_run();
  end
endmodule